// File: doc/BRIEF.md
# Two-Phase Pipeline Stage Scheduler

This block drives a four-stage in-order pipeline (fetch, decode, execute, memory-with-writeback) in which exactly two stages work in any clock cycle. A one-bit phase register alternates between an even and an odd phase. Fetch and execute run in the even phase. Decode and memory run in the odd phase. A new instruction therefore enters every second cycle. Because the memory stage also performs writeback, no register sits between those two steps.

The scheduler also owns the only port to one single-port synchronous memory. Instruction fetch uses the port in even cycles and data access uses it in odd cycles, so the two never compete for it. The memory returns read data one cycle after the request. The scheduler captures that data into an instruction register or a load-data register, chosen by the phase that issued the request. A run input pauses the whole schedule and resumes it at the same phase.

Top module: `duo_phase_sched`

## Requirements
- R1: While reset is high, and after it while run is low, all four stage enables, the register-file strobe, mem_en and mem_we are low. instr_valid and load_valid are low, and instr_word and load_word are zero.
- R2: In an even cycle with run high, fetch and execute are enabled, and decode and memory are not.
- R3: In an odd cycle with run high, decode and memory are enabled, and fetch and execute are not.
- R4: The phase resets to even and flips on every clock edge at which run is high, so fetch is never enabled in two consecutive cycles.
- R5: While run is low, all stage enables, the register-file strobe and mem_en/mem_we stay low and the phase holds. When run returns, the schedule continues in the phase it held.
- R6: The register-file strobe is high exactly in even cycles with run high.
- R7: In an even cycle, mem_en equals fetch_req, mem_addr equals fetch_pc, mem_be is all ones and mem_we is low.
- R8: In an odd cycle, mem_en equals data_req, mem_addr equals data_addr, and mem_be and mem_wdata follow data_be and data_wdata. mem_we equals data_req AND data_we, where bit i of the byte strobe selects byte lane i (bits 8i+7 down to 8i).
- R9: Read data for a fetch issued in cycle c is in instr_word with instr_valid high in cycle c+2, and load_word is unchanged.
- R10: Read data for a load (data_req high, data_we low) issued in cycle c is in load_word with load_valid high in cycle c+2, and instr_word is unchanged. A store captures nothing.
- R11: A fetch_req in an odd cycle and a data_req in an even cycle are ignored: they cause no memory access and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low pauses the schedule |
| en_fetch | output | 1 | Fetch stage enable |
| en_decode | output | 1 | Decode stage enable |
| en_exec | output | 1 | Execute stage enable |
| en_mem | output | 1 | Memory/writeback stage enable |
| rf_strobe | output | 1 | Register-file read/write strobe |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_pc | input | AW | Program counter of the fetch |
| data_req | input | 1 | Data access request |
| data_we | input | 1 | Data access is a store |
| data_addr | input | AW | Data address |
| data_wdata | input | DW | Store data |
| data_be | input | DW/8 | Store byte strobes |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_be | output | DW/8 | Memory port byte strobes |
| mem_rdata | input | DW | Memory read data, one cycle after request |
| instr_word | output | DW | Captured instruction |
| instr_valid | output | 1 | instr_word updated this cycle |
| load_word | output | DW | Captured load data |
| load_valid | output | 1 | load_word updated this cycle |

## Verification
The assertions check the cycle-level invariants on every clock. These are the exclusive pairing of stages, fetch never repeating in consecutive cycles, and the register strobe and memory writes staying in their own phase. They also check that the paused schedule holds its phase and that the two capture pulses never coincide. Only the bench scenarios can show that the right data lands in the right register two cycles later. The same holds for byte-strobed stores read back through a later load, for requests in the wrong phase being dropped, and for a pause resuming in the phase it held.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    typedef struct packed {
        logic fetch;
        logic decode;
        logic exec;
        logic mem;
    } stage_en_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FETCH = 2'd1,
        SRC_LOAD  = 2'd2
    } rd_src_e;

    // Stage pair active for a given phase; nothing when the pipeline is idle.
    function automatic stage_en_t stage_pair(input phase_e ph, input logic live);
        stage_en_t s;
        s = '0;
        if (live) begin
            if (ph == PH_EVEN) begin
                s.fetch = 1'b1;
                s.exec  = 1'b1;
            end else begin
                s.decode = 1'b1;
                s.mem    = 1'b1;
            end
        end
        return s;
    endfunction

    function automatic phase_e phase_advance(input phase_e ph, input logic live);
        phase_e n;
        n = ph;
        if (live) begin
            n = (ph == PH_EVEN) ? PH_ODD : PH_EVEN;
        end
        return n;
    endfunction

endpackage

// File: rtl/dps_phase_gen.sv
module dps_phase_gen
    import dps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_en,
    output phase_e    phase,
    output logic      live,
    output stage_en_t stages
);

    phase_e phase_q;

    assign live = run_en & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_EVEN;
        end else begin
            phase_q <= phase_advance(phase_q, live);
        end
    end

    assign phase  = phase_q;
    assign stages = stage_pair(phase_q, live);

endmodule

// File: rtl/dps_mem_arb.sv
module dps_mem_arb
    import dps_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  phase_e          phase,
    input  logic            live,
    input  logic            fetch_req,
    input  logic [AW-1:0]   fetch_pc,
    input  logic            data_req,
    input  logic            data_we,
    input  logic [AW-1:0]   data_addr,
    input  logic [DW-1:0]   data_wdata,
    input  logic [BW-1:0]   data_be,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [BW-1:0]   mem_be,
    output rd_src_e         issue_src
);

    logic odd;
    assign odd = (phase == PH_ODD);

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        issue_src = SRC_NONE;
        if (live) begin
            if (odd) begin
                mem_en = data_req;
                mem_we = data_req & data_we;
                if (data_req && !data_we) begin
                    issue_src = SRC_LOAD;
                end
            end else begin
                mem_en = fetch_req;
                if (fetch_req) begin
                    issue_src = SRC_FETCH;
                end
            end
        end
    end

    assign mem_addr  = odd ? data_addr : fetch_pc;
    assign mem_wdata = odd ? data_wdata : '0;

    // Per-lane strobe: fetches read every lane, data accesses use caller lanes.
    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign mem_be[g] = odd ? data_be[g] : 1'b1;
    end

endmodule

// File: rtl/dps_rd_capture.sv
module dps_rd_capture
    import dps_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_src_e       issue_src,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] instr_word,
    output logic          instr_valid,
    output logic [DW-1:0] load_word,
    output logic          load_valid
);

    rd_src_e pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= SRC_NONE;
            instr_word  <= '0;
            load_word   <= '0;
            instr_valid <= 1'b0;
            load_valid  <= 1'b0;
        end else begin
            pend_q      <= issue_src;
            instr_valid <= (pend_q == SRC_FETCH);
            load_valid  <= (pend_q == SRC_LOAD);
            if (pend_q == SRC_FETCH) begin
                instr_word <= mem_rdata;
            end
            if (pend_q == SRC_LOAD) begin
                load_word <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/duo_phase_sched.sv
module duo_phase_sched
    import dps_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    output logic          en_fetch,
    output logic          en_decode,
    output logic          en_exec,
    output logic          en_mem,
    output logic          rf_strobe,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_pc,
    input  logic          data_req,
    input  logic          data_we,
    input  logic [AW-1:0] data_addr,
    input  logic [DW-1:0] data_wdata,
    input  logic [BW-1:0] data_be,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [BW-1:0] mem_be,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] instr_word,
    output logic          instr_valid,
    output logic [DW-1:0] load_word,
    output logic          load_valid
);

    phase_e    phase_w;
    logic      phase_bit;
    logic      live_w;
    stage_en_t stages_w;
    rd_src_e   src_w;

    dps_phase_gen u_phase (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .phase  (phase_w),
        .live   (live_w),
        .stages (stages_w)
    );

    assign phase_bit = (phase_w == PH_ODD);
    assign en_fetch  = stages_w.fetch;
    assign en_decode = stages_w.decode;
    assign en_exec   = stages_w.exec;
    assign en_mem    = stages_w.mem;
    assign rf_strobe = live_w & (phase_w == PH_EVEN);

    dps_mem_arb #(.AW(AW), .DW(DW)) u_arb (
        .phase      (phase_w),
        .live       (live_w),
        .fetch_req  (fetch_req),
        .fetch_pc   (fetch_pc),
        .data_req   (data_req),
        .data_we    (data_we),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .data_be    (data_be),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .issue_src  (src_w)
    );

    dps_rd_capture #(.DW(DW)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .issue_src   (src_w),
        .mem_rdata   (mem_rdata),
        .instr_word  (instr_word),
        .instr_valid (instr_valid),
        .load_word   (load_word),
        .load_valid  (load_valid)
    );

endmodule

// File: rtl/dps_sched_checker.sv
module dps_sched_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          run_en,
    input logic          phase_bit,
    input logic          en_fetch,
    input logic          en_decode,
    input logic          en_exec,
    input logic          en_mem,
    input logic          rf_strobe,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] fetch_pc,
    input logic          instr_valid,
    input logic          load_valid
);

    p_even_pair_r2: assert property (@(posedge clk) disable iff (rst)
        en_fetch |-> (en_exec && !en_decode && !en_mem));

    p_odd_pair_r3: assert property (@(posedge clk) disable iff (rst)
        en_decode |-> (en_mem && !en_fetch && !en_exec));

    p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
        en_fetch |=> !en_fetch);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !(en_fetch || en_decode || en_exec || en_mem || mem_en || rf_strobe));

    p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(phase_bit));

    p_rf_even_r6: assert property (@(posedge clk) disable iff (rst)
        rf_strobe |-> en_fetch);

    p_fetch_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && en_fetch) |-> (mem_addr == fetch_pc && !mem_we));

    p_write_odd_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (en_mem && mem_en));

    p_single_capture_r9: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && load_valid));

endmodule

bind duo_phase_sched dps_sched_checker #(.AW(AW)) u_sched_chk (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .phase_bit   (phase_bit),
    .en_fetch    (en_fetch),
    .en_decode   (en_decode),
    .en_exec     (en_exec),
    .en_mem      (en_mem),
    .rf_strobe   (rf_strobe),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .fetch_pc    (fetch_pc),
    .instr_valid (instr_valid),
    .load_valid  (load_valid)
);

// File: tb/test_duo_phase_sched.sv
`timescale 1ns/1ps
module test_duo_phase_sched;

    logic        clk = 1'b0;
    logic        rst;
    logic        run_en;
    logic        en_fetch, en_decode, en_exec, en_mem, rf_strobe;
    logic        fetch_req;
    logic [31:0] fetch_pc;
    logic        data_req, data_we;
    logic [31:0] data_addr, data_wdata;
    logic [3:0]  data_be;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata;
    logic [31:0] instr_word, load_word;
    logic        instr_valid, load_valid;

    always #2.5 clk = ~clk;

    duo_phase_sched i_duo_phase_sched (
        .clk(clk), .rst(rst), .run_en(run_en),
        .en_fetch(en_fetch), .en_decode(en_decode), .en_exec(en_exec), .en_mem(en_mem),
        .rf_strobe(rf_strobe),
        .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .data_req(data_req), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata), .data_be(data_be),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .instr_word(instr_word), .instr_valid(instr_valid),
        .load_word(load_word), .load_valid(load_valid)
    );

    // Bench-side single-port synchronous memory, 64 words
    logic [31:0] tbmem [0:63];
    initial begin
        for (int i = 0; i < 64; i++) tbmem[i] = 32'hA500_0000 + i * 32'h0101_0101;
        mem_rdata = '0;
    end
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= tbmem[mem_addr[7:2]];
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) tbmem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
    end

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    logic done = 1'b0;
    logic exp_odd;
    logic mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    typedef struct {
        logic        is_load;
        logic [31:0] data;
        int          due;
    } exp_t;
    exp_t sbq[$];
    logic [31:0] exp_instr = '0;
    logic [31:0] exp_load  = '0;

    // Monitor: pops scoreboard items as captures appear
    always @(negedge clk) begin
        if (mon_on) begin
            if (sbq.size() > 0 && sbq[0].due == cyc) begin
                if (sbq[0].is_load) begin
                    chk(load_valid, "R10 load_valid", {31'b0, load_valid}, 32'd1);
                    chk(load_word == sbq[0].data, "R10 load_word", load_word, sbq[0].data);
                    chk(instr_word == exp_instr, "R10 instr_word kept", instr_word, exp_instr);
                    exp_load = sbq[0].data;
                end else begin
                    chk(instr_valid, "R9 instr_valid", {31'b0, instr_valid}, 32'd1);
                    chk(instr_word == sbq[0].data, "R9 instr_word", instr_word, sbq[0].data);
                    chk(load_word == exp_load, "R9 load_word kept", load_word, exp_load);
                    exp_instr = sbq[0].data;
                end
                void'(sbq.pop_front());
            end else begin
                chk(!instr_valid && !load_valid, "R11 no stray capture",
                    {30'b0, instr_valid, load_valid}, 32'd0);
            end
        end
    end

    task automatic step(input logic run, input logic fr, input logic [31:0] pc,
                        input logic dr, input logic we, input logic [31:0] da,
                        input logic [31:0] wd, input logic [3:0] be);
        logic prev_run;
        logic ex_en, ex_we;
        prev_run = run_en;
        @(posedge clk);
        if (prev_run) exp_odd = ~exp_odd;   // R4 phase flips on a running edge
        #1;
        run_en = run; fetch_req = fr; fetch_pc = pc;
        data_req = dr; data_we = we; data_addr = da; data_wdata = wd; data_be = be;
        @(negedge clk);
        if (!run) begin
            chk({en_fetch, en_decode, en_exec, en_mem, rf_strobe} == 5'b0, "R5 paused enables",
                {27'b0, en_fetch, en_decode, en_exec, en_mem, rf_strobe}, 32'd0);
        end else if (!exp_odd) begin
            chk({en_fetch, en_decode, en_exec, en_mem} == 4'b1010, "R2 even pair",
                {28'b0, en_fetch, en_decode, en_exec, en_mem}, 32'b1010);
        end else begin
            chk({en_fetch, en_decode, en_exec, en_mem} == 4'b0101, "R3 odd pair",
                {28'b0, en_fetch, en_decode, en_exec, en_mem}, 32'b0101);
        end
        chk(rf_strobe == (run && !exp_odd), "R6 rf_strobe", {31'b0, rf_strobe}, {31'b0, run && !exp_odd});
        ex_en = run && (exp_odd ? dr : fr);
        ex_we = run && exp_odd && dr && we;
        chk(mem_en == ex_en, (exp_odd && fr) || (!exp_odd && dr) ? "R11 mem_en" : "R7/R8 mem_en",
            {31'b0, mem_en}, {31'b0, ex_en});
        chk(mem_we == ex_we, "R8 mem_we", {31'b0, mem_we}, {31'b0, ex_we});
        if (ex_en && !exp_odd) begin
            chk(mem_addr == pc, "R7 fetch addr", mem_addr, pc);
            chk(mem_be == 4'hF, "R7 fetch be", {28'b0, mem_be}, 32'hF);
            sbq.push_back('{is_load: 1'b0, data: tbmem[pc[7:2]], due: cyc + 2});
        end
        if (ex_en && exp_odd) begin
            chk(mem_addr == da, "R8 data addr", mem_addr, da);
            chk(mem_be == be, "R8 data be", {28'b0, mem_be}, {28'b0, be});
            if (we) chk(mem_wdata == wd, "R8 wdata", mem_wdata, wd);
            else sbq.push_back('{is_load: 1'b1, data: tbmem[da[7:2]], due: cyc + 2});
        end
    endtask

    task automatic idle_run(input logic run);
        step(run, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 4'h0);
    endtask

    initial begin
        rst = 1'b1; run_en = 1'b1;
        fetch_req = 1'b1; fetch_pc = 32'h4; data_req = 1'b1; data_we = 1'b1;
        data_addr = 32'h8; data_wdata = 32'hFFFF_FFFF; data_be = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset holds everything quiet even with run and requests high
        chk({en_fetch, en_decode, en_exec, en_mem, rf_strobe, mem_en, mem_we} == 7'b0, "R1 reset enables",
            {25'b0, en_fetch, en_decode, en_exec, en_mem, rf_strobe, mem_en, mem_we}, 32'd0);
        chk(!instr_valid && !load_valid && instr_word == 0 && load_word == 0, "R1 reset capture",
            instr_word | load_word, 32'd0);
        @(posedge clk); #1;
        rst = 1'b0; run_en = 1'b0; fetch_req = 0; data_req = 0; data_we = 0;
        @(negedge clk);
        chk({en_fetch, en_decode, en_exec, en_mem, rf_strobe, mem_en} == 6'b0, "R1 idle after reset",
            {26'b0, en_fetch, en_decode, en_exec, en_mem, rf_strobe, mem_en}, 32'd0);
        exp_odd = 1'b0;
        mon_on  = 1'b1;

        // Plain run: fetch on even, load on odd (R2, R3, R4, R7, R9, R10)
        step(1, 1, 32'h10, 0, 0, 32'h0,  32'h0, 4'h0);
        step(1, 0, 32'h0,  1, 0, 32'h20, 32'h0, 4'hF);
        step(1, 1, 32'h14, 0, 0, 32'h0,  32'h0, 4'h0);
        step(1, 0, 32'h0,  1, 0, 32'h24, 32'h0, 4'hF);
        // Wrong-phase requests held on both phases (R11)
        step(1, 1, 32'h18, 1, 0, 32'h28, 32'h0, 4'hF);
        step(1, 1, 32'h1C, 1, 0, 32'h2C, 32'h0, 4'hF);
        // Byte-strobed store then load back (R8, R10)
        step(1, 0, 32'h0,  0, 0, 32'h0,  32'h0, 4'h0);
        step(1, 0, 32'h0,  1, 1, 32'h30, 32'h1234_5678, 4'b0101);
        step(1, 1, 32'h30, 0, 0, 32'h0,  32'h0, 4'h0);
        step(1, 0, 32'h0,  1, 0, 32'h30, 32'h0, 4'hF);
        idle_run(1);
        // Pause after an even cycle with requests held (R5), resume odd
        step(0, 1, 32'h40, 1, 1, 32'h34, 32'hDEAD_BEEF, 4'hF);
        step(0, 1, 32'h40, 1, 1, 32'h34, 32'hDEAD_BEEF, 4'hF);
        step(0, 1, 32'h40, 1, 0, 32'h34, 32'h0, 4'hF);
        step(1, 0, 32'h0,  1, 0, 32'h34, 32'h0, 4'hF);
        step(1, 1, 32'h44, 0, 0, 32'h0,  32'h0, 4'h0);
        // Pause after odd cycle, resume even (R5)
        idle_run(1);
        idle_run(0);
        idle_run(0);
        step(1, 1, 32'h48, 0, 0, 32'h0,  32'h0, 4'h0);
        step(1, 0, 32'h0,  1, 0, 32'h48, 32'h0, 4'hF);
        repeat (4) idle_run(1);
        chk(sbq.size() == 0, "R9 scoreboard drained", sbq.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule